// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating dual-slope converter. A start request sets off a conversion. The integrator is cleared for one clock. The unknown input is then applied for a fixed number of clocks. After that, the integrator input is switched to the reference and a counter measures how many clocks the integrator needs to run back down to its threshold. The measured count is stored in a result register, and a one-clock done pulse marks each update of that register.

The analog integrator and the threshold comparator are outside the block. The comparator flag arrives asynchronously and passes through a two-flop synchronizer before the controller acts on it. Because the same clock times both slopes, drift in the clock frequency does not affect the result. If the integrator has not come back down by the time the count reaches its ceiling, the result pins at all ones and an overrange flag is set. A start request that arrives while a conversion is running has no effect.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is asserted, busy, selRef, intClear, doneP and overRange are all 0, and result is 0.
- R2: A startReq sampled high while busy is 0 makes intClear high for exactly one clock, starting on the next clock. busy is 1 from that clock until the conversion ends.
- R3: After the clear clock, selRef stays 0 (input applied) for exactly 2^RES_BITS−1 clocks with busy high. selRef then goes to 1 (reference applied).
- R4: compTrip reaches the control logic through two flip-flops. With the reference applied, the discharge counter starts at 0 and advances by one each clock. A synchronized trip seen at count c stores c in result.
- R5: doneP is high for exactly one clock, in the first clock in which the new result and overRange are visible. busy is 0 in that clock.
- R6: If no synchronized trip has been seen when the discharge count equals 2^RES_BITS−1, result becomes all ones and overRange becomes 1.
- R7: If a synchronized trip and the count 2^RES_BITS−1 fall in the same clock, the trip wins: result is all ones and overRange is 0.
- R8: startReq while busy is 1 is ignored. The running conversion is not restarted, and no new conversion follows it.
- R9: overRange keeps its value until the next result update, and a conversion that ends on a trip clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both slopes and all registers |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a conversion |
| compTrip | input | 1 | Asynchronous comparator flag, high when the integrator is at or past its threshold |
| selRef | output | 1 | 1 selects the reference for the integrator, 0 selects the unknown input |
| intClear | output | 1 | Integrator reset, high for one clock at the start of a conversion |
| busy | output | 1 | High while a conversion is in progress |
| doneP | output | 1 | One-clock pulse that marks a result update |
| result | output | RES_BITS | Last measured discharge count |
| overRange | output | 1 | Set when the last conversion hit the count ceiling without a trip |

## Verification
Two events can fall in the same clock: the synchronized comparator trip and the discharge counter reaching its ceiling. A sweep of input levels against a fixed reference includes the level for which the bench's arithmetic model (two synchronizer clocks plus the ceiling of the charge divided by the reference) lands exactly on the ceiling. In that case the result must be all ones with overRange clear. The next input level, one step higher, must give the same result with overRange set.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_INTEG = 2'd2,
    ST_DEINT = 2'd3
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;   // counter back to zero
    logic cntInc;   // counter advances by one
    logic capture;  // store the count, clear overrange
    logic saturate; // store all ones, set overrange
  } dpStrobe_t;

endpackage

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                compTrip,
  input  dpStrobe_t           strobe,
  output logic                compSync,
  output logic                cntAtIntEnd,
  output logic                cntAtLimit,
  output logic [RES_BITS-1:0] result,
  output logic                overRange,
  output logic                doneP
);
  localparam logic [RES_BITS-1:0] CNT_MAX     = '1;
  localparam logic [RES_BITS-1:0] CNT_INT_END = CNT_MAX - 1'b1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic [RES_BITS-1:0]    cnt;

  // metastability chain for the comparator flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], compTrip};
  end
  assign compSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign cntAtIntEnd = (cnt == CNT_INT_END);
  assign cntAtLimit  = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      overRange <= 1'b0;
      doneP     <= 1'b0;
    end else begin
      doneP <= strobe.capture | strobe.saturate;
      if (strobe.capture) begin
        result    <= cnt;
        overRange <= 1'b0;
      end else if (strobe.saturate) begin
        result    <= CNT_MAX;
        overRange <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsc_control.sv
module dsc_control
  import dsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      compSync,
  input  logic      cntAtIntEnd,
  input  logic      cntAtLimit,
  output dpStrobe_t strobe,
  output logic      selRef,
  output logic      intClear,
  output logic      busy
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) stateNxt = ST_CLEAR;
      end
      ST_CLEAR: begin
        strobe.cntClr = 1'b1;
        stateNxt      = ST_INTEG;
      end
      ST_INTEG: begin
        if (cntAtIntEnd) begin
          strobe.cntClr = 1'b1;
          stateNxt      = ST_DEINT;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DEINT: begin
        if (compSync) begin
          strobe.capture = 1'b1;
          strobe.cntClr  = 1'b1;
          stateNxt       = ST_IDLE;
        end else if (cntAtLimit) begin
          strobe.saturate = 1'b1;
          strobe.cntClr   = 1'b1;
          stateNxt        = ST_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign intClear = (state == ST_CLEAR);
  assign selRef   = (state == ST_DEINT);
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dsc_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                compTrip,
  output logic                selRef,
  output logic                intClear,
  output logic                busy,
  output logic                doneP,
  output logic [RES_BITS-1:0] result,
  output logic                overRange
);
  dpStrobe_t strobe;
  logic      compSync;
  logic      cntAtIntEnd;
  logic      cntAtLimit;

  dsc_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .compSync    (compSync),
    .cntAtIntEnd (cntAtIntEnd),
    .cntAtLimit  (cntAtLimit),
    .strobe      (strobe),
    .selRef      (selRef),
    .intClear    (intClear),
    .busy        (busy)
  );

  dsc_datapath #(
    .RES_BITS    (RES_BITS),
    .SYNC_STAGES (2)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .compTrip    (compTrip),
    .strobe      (strobe),
    .compSync    (compSync),
    .cntAtIntEnd (cntAtIntEnd),
    .cntAtLimit  (cntAtLimit),
    .result      (result),
    .overRange   (overRange),
    .doneP       (doneP)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic                selRef,
  input logic                intClear,
  input logic                busy,
  input logic                doneP,
  input logic [RES_BITS-1:0] result,
  input logic                overRange
);
  localparam int INT_LEN = (1 << RES_BITS) - 1;

  logic [RES_BITS:0] integCnt;

  // counts clocks with the input applied since the last clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               integCnt <= '0;
    else if (intClear)                       integCnt <= '0;
    else if (busy && !selRef && !intClear)   integCnt <= integCnt + 1'b1;
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (intClear && busy));

  a_r2_clear_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    intClear |=> (!intClear && busy));

  a_r3_integ_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selRef) |-> (integCnt == (RES_BITS+1)'(INT_LEN)));

  a_r3_ref_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    selRef |-> (busy && !intClear));

  a_r5_done_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !busy);

  a_r5_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !doneP |-> $stable(result));

  a_r9_ovr_held: assert property (@(posedge clk) disable iff (!rstN)
    !doneP |-> $stable(overRange));

  a_r6_ovr_full_scale: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (&result));

  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !selRef && !intClear) |=> !intClear);
endmodule

bind dual_slope_ctrl dsc_checker #(.RES_BITS(RES_BITS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .selRef    (selRef),
  .intClear  (intClear),
  .busy      (busy),
  .doneP     (doneP),
  .result    (result),
  .overRange (overRange)
);

// File: tb/sim_dual_slope_ctrl.sv
`timescale 1ns/1ps
module sim_dual_slope_ctrl;
  localparam int NB  = 5;
  localparam int MAX = (1 << NB) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          compTrip;
  logic          selRef, intClear, busy, doneP, overRange;
  logic [NB-1:0] result;

  int checks = 0;
  int fails  = 0;
  int vinCur = 0;
  int vrefCur = 1;
  int level  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_slope_ctrl #(.RES_BITS(NB)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .compTrip(compTrip),
    .selRef(selRef), .intClear(intClear), .busy(busy), .doneP(doneP),
    .result(result), .overRange(overRange)
  );

  // behavioural integrator: ramps up on the input, down on the reference
  always @(posedge clk) begin
    if (intClear)            level <= 0;
    else if (busy && !selRef) level <= level + vinCur;
    else if (selRef)         level <= level - vrefCur;
  end
  assign compTrip = (level <= 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runConv(input int vin, input int vref, input bit prevOvr);
    int clr = 0;
    int integ = 0;
    int cyc = 0;
    int expRes;
    int expOvr;
    vinCur  = vin;
    vrefCur = vref;
    if (vin == 0) expRes = 0;
    else expRes = (vin * MAX + vref - 1) / vref + 2;
    expOvr = 0;
    if (expRes > MAX) begin
      expRes = MAX;
      expOvr = 1;
    end
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1 && intClear == 1'b1, "R2 clear after start", int'(intClear), 1);
    while (!doneP && cyc < 4 * MAX + 20) begin
      cyc++;
      if (intClear) clr++;
      if (busy && !selRef && !intClear) integ++;
      startReq = (cyc == 10);   // R8: request while busy
      @(negedge clk);
    end
    startReq = 1'b0;
    check(clr == 1, "R2 clear length", clr, 1);
    check(integ == MAX, "R3 integrate length", integ, MAX);
    check(busy == 1'b0, "R5 busy low at done", int'(busy), 0);
    check(int'(result) == expRes, expOvr ? "R6 saturated result" :
          (expRes == MAX ? "R7 trip at limit" : "R4 measured count"),
          int'(result), expRes);
    check(int'(overRange) == expOvr, prevOvr ? "R9 overrange after prior overrange" :
          (expRes == MAX && !expOvr ? "R7 no overrange" : "R6 overrange flag"),
          int'(overRange), expOvr);
    @(negedge clk);
    check(doneP == 1'b0, "R5 done one clock", int'(doneP), 0);
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && intClear == 1'b0, "R8 no restart", int'(busy), 0);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    bit lastOvr;
    repeat (3) @(negedge clk);
    check(busy == 0 && selRef == 0 && intClear == 0 && doneP == 0 &&
          overRange == 0 && result == '0, "R1 reset state", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && doneP == 0, "R1 idle after reset", int'(busy), 0);
    lastOvr = 1'b0;
    // fine sweep against a large reference, crossing the ceiling (R6/R7)
    for (int v = 0; v <= 33; v++) begin
      runConv(v, 32, lastOvr);
      lastOvr = overRange;
    end
    // coarse sweep against a small reference
    for (int v = 0; v <= 6; v++) begin
      runConv(v, 5, lastOvr);
      lastOvr = overRange;
    end
    // overrange followed by a normal conversion (R9)
    runConv(40, 32, lastOvr);
    lastOvr = overRange;
    runConv(3, 32, lastOvr);
    finished = 1'b1;
    report();
  end
endmodule